// File: doc/BRIEF.md
# Serial Dot/Control Register Receiver

This block is the receive side of a chainable LED matrix driver. A host drives a slow serial port made of a shift clock, an active-low enable, a register-select level and a data bit. Each write goes either into a 160-bit pixel shift register or into an 8-bit control shift register. When the write ends, the block moves the shifted contents into a pixel latch that feeds the LED drivers, or into one of two 7-bit control words. The latched pattern keeps driving the display while the next pattern is being shifted in.

The serial output lets several devices share one data line. Normally it presents the last stage of the selected shift register. A mode bit in control word 1 instead routes the data input straight to the output during control writes, so a whole chain of devices can take the same control byte in 8 serial clocks.

All serial pins are sampled into one system clock domain, and their edges are detected there. The serial port has no valid/ready handshake and cannot apply back-pressure. The host must therefore hold every level on the serial pins for at least three system clock cycles, and it must not move the serial clock in the same sample window in which it changes the enable.

Top module: `ledmx_rx`

## Requirements
- R1: The level of `ser_rs` is captured when `ser_ce_n` falls: 0 selects the pixel register, 1 selects the control register. Changes on `ser_rs` while `ser_ce_n` stays low do not change the target.
- R2: A rising `ser_clk` while `ser_ce_n` is low shifts `ser_din` into bit 0 of the selected shift register, and older bits move toward the top, so the first bit sent ends at the top bit (pixel bit 159). Rising `ser_clk` edges while `ser_ce_n` is high shift nothing.
- R3: `dot_q` takes the pixel shift register contents only after `ser_ce_n` has returned high and `ser_clk` is seen low. Until then it keeps the previous pattern, including during the whole load.
- R4: Each write produces exactly one transfer, whether `ser_clk` is already low when `ser_ce_n` rises or falls low later.
- R5: Control bytes arrive most significant bit first. On transfer, if bit 7 of the control shift register is 0, bits 6..0 go to `cw0`; if it is 1, they go to `cw1`. The other word keeps its value.
- R6: When bit 0 of `cw1` is 0, `ser_dout` is bit 159 of the pixel shift register while pixel is selected, and bit 7 of the control shift register while control is selected.
- R7: When bit 0 of `cw1` is 1 and control is selected, `ser_dout` follows `ser_din` combinationally. While pixel is selected, `ser_dout` still presents pixel shift bit 159.
- R8: `cfg_rst_n` low clears `cw0`, `cw1` and the control shift register, which leaves the device in sleep with serial output mode. It changes neither the pixel shift register nor `dot_q`.
- R9: A transfer is visible on the outputs on the third system clock edge after the enabling level change on the pins, and not earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sys_clk | input | 1 | System clock that samples all serial pins |
| cfg_rst_n | input | 1 | Asynchronous active-low reset of the control state; pixel data is kept |
| ser_clk | input | 1 | Serial shift clock, active on its rising edge |
| ser_ce_n | input | 1 | Active-low write enable; its rising edge ends a write |
| ser_rs | input | 1 | Register select, captured on the falling edge of `ser_ce_n` |
| ser_din | input | 1 | Serial data input |
| ser_dout | output | 1 | Serial data output for chaining |
| dot_q | output | 160 | Latched pixel pattern; bit 8c+r is column c, row r, and row 0 has no LED |
| cw0 | output | 7 | Control word 0 (brightness and sleep fields) |
| cw1 | output | 7 | Control word 1; bit 0 selects pass-through output |

## Verification
The bench ends one write with the serial clock still high and another with it already low. A design with the latch condition wrong would update `dot_q` during the high phase, would miss the transfer, or would transfer twice. It moves `ser_rs` after the enable falls, which catches a design that samples the select continuously. It pulses the serial clock with the enable high, which catches a design that shifts without the enable. It switches `ser_din` in pass-through mode while pixel is selected and while control is selected, which catches an output mux that ignores the target. Finally it resets the control state after pixel data is loaded, to catch a reset that also wipes the pattern.

// File: rtl/ledmx_pkg.sv
package ledmx_pkg;
  // Target of a serial write, taken from the select pin when the enable falls.
  typedef enum logic {
    TGT_DOT = 1'b0,
    TGT_CTL = 1'b1
  } tgt_e;

  // Bit of control word 1 that turns on the pass-through output.
  localparam int PASS_BIT = 0;
endpackage

// File: rtl/ledmx_sync.sv
module ledmx_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[i] <= RST_VAL;
        else        stg[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[i] <= RST_VAL;
        else        stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/ledmx_shift.sv
module ledmx_shift
  import ledmx_pkg::*;
#(
  parameter int DOT_BITS = 160,
  parameter int CTL_BITS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                shift_en,
  input  tgt_e                tgt,
  input  logic                din,
  output logic [DOT_BITS-1:0] dot_sr,
  output logic [CTL_BITS-1:0] ctl_sr
);
  // The pixel register has no reset: the reset pin leaves pixel data alone.
  always_ff @(posedge clk) begin
    if (shift_en && tgt == TGT_DOT)
      dot_sr <= {dot_sr[DOT_BITS-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ctl_sr <= '0;
    else if (shift_en && tgt == TGT_CTL)
      ctl_sr <= {ctl_sr[CTL_BITS-2:0], din};
  end
endmodule

// File: rtl/ledmx_xfer.sv
module ledmx_xfer
  import ledmx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ce_high,
  input  logic ce_rise,
  input  logic clk_low,
  input  tgt_e tgt,
  output logic fire_dot,
  output logic fire_ctl
);
  logic pend;
  logic fire;

  // One transfer per write: the request is armed when the enable rises
  // and is consumed the first cycle the serial clock is seen low.
  assign fire     = ce_high && clk_low && (pend || ce_rise);
  assign fire_dot = fire && (tgt == TGT_DOT);
  assign fire_ctl = fire && (tgt == TGT_CTL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= 1'b0;
    else        pend <= (pend || ce_rise) && ce_high && !fire;
  end
endmodule

// File: rtl/ledmx_rx.sv
module ledmx_rx
  import ledmx_pkg::*;
#(
  parameter int DOT_BITS    = 160,
  parameter int CTL_BITS    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                sys_clk,
  input  logic                cfg_rst_n,
  input  logic                ser_clk,
  input  logic                ser_ce_n,
  input  logic                ser_rs,
  input  logic                ser_din,
  output logic                ser_dout,
  output logic [DOT_BITS-1:0] dot_q,
  output logic [CTL_BITS-2:0] cw0,
  output logic [CTL_BITS-2:0] cw1
);
  localparam int CW_W  = CTL_BITS - 1;
  localparam int SEL_B = CTL_BITS - 1;

  // Synchronized pins: {clk, ce_n, rs, din}. Idle value has the enable high.
  logic [3:0] pins_s;
  logic       clk_s, cen_s, rs_s, din_s;
  logic       clk_p, cen_p;

  ledmx_sync #(
    .W      (4),
    .STAGES (SYNC_STAGES),
    .RST_VAL(4'b0100)
  ) u_sync (
    .clk  (sys_clk),
    .rst_n(cfg_rst_n),
    .d    ({ser_clk, ser_ce_n, ser_rs, ser_din}),
    .q    (pins_s)
  );

  assign {clk_s, cen_s, rs_s, din_s} = pins_s;

  always_ff @(posedge sys_clk or negedge cfg_rst_n) begin
    if (!cfg_rst_n) begin
      clk_p <= 1'b0;
      cen_p <= 1'b1;
    end else begin
      clk_p <= clk_s;
      cen_p <= cen_s;
    end
  end

  logic clk_rise, ce_fall, ce_rise, shift_en;
  assign clk_rise = clk_s && !clk_p;
  assign ce_fall  = cen_p && !cen_s;
  assign ce_rise  = !cen_p && cen_s;
  assign shift_en = clk_rise && !cen_s;

  // Target select, captured once per write.
  tgt_e rs_sel;
  always_ff @(posedge sys_clk or negedge cfg_rst_n) begin
    if (!cfg_rst_n)   rs_sel <= TGT_DOT;
    else if (ce_fall) rs_sel <= tgt_e'(rs_s);
  end

  logic [DOT_BITS-1:0] dot_sr;
  logic [CTL_BITS-1:0] ctl_sr;

  ledmx_shift #(
    .DOT_BITS(DOT_BITS),
    .CTL_BITS(CTL_BITS)
  ) u_shift (
    .clk     (sys_clk),
    .rst_n   (cfg_rst_n),
    .shift_en(shift_en),
    .tgt     (rs_sel),
    .din     (din_s),
    .dot_sr  (dot_sr),
    .ctl_sr  (ctl_sr)
  );

  logic fire_dot, fire_ctl;

  ledmx_xfer u_xfer (
    .clk     (sys_clk),
    .rst_n   (cfg_rst_n),
    .ce_high (cen_s),
    .ce_rise (ce_rise),
    .clk_low (!clk_s),
    .tgt     (rs_sel),
    .fire_dot(fire_dot),
    .fire_ctl(fire_ctl)
  );

  // Pixel latch: not touched by the control reset.
  always_ff @(posedge sys_clk) begin
    if (fire_dot) dot_q <= dot_sr;
  end

  always_ff @(posedge sys_clk or negedge cfg_rst_n) begin
    if (!cfg_rst_n) begin
      cw0 <= '0;
      cw1 <= '0;
    end else if (fire_ctl) begin
      if (ctl_sr[SEL_B]) cw1 <= ctl_sr[CW_W-1:0];
      else               cw0 <= ctl_sr[CW_W-1:0];
    end
  end

  // Chain output: pass-through only for control writes in that mode.
  always_comb begin
    if (rs_sel == TGT_CTL)
      ser_dout = cw1[PASS_BIT] ? ser_din : ctl_sr[SEL_B];
    else
      ser_dout = dot_sr[DOT_BITS-1];
  end
endmodule

// File: rtl/ledmx_rx_chk.sv
module ledmx_rx_chk #(
  parameter int DOT_BITS = 160,
  parameter int CTL_BITS = 8
) (
  input logic                sys_clk,
  input logic                cfg_rst_n,
  input logic                ce_fall,
  input logic                cen_s,
  input logic                fire_dot,
  input logic                fire_ctl,
  input logic                rs_sel,
  input logic [DOT_BITS-1:0] dot_sr,
  input logic [CTL_BITS-1:0] ctl_sr,
  input logic [DOT_BITS-1:0] dot_q,
  input logic [CTL_BITS-2:0] cw0,
  input logic [CTL_BITS-2:0] cw1
);
  a_r1_sel_holds: assert property (@(posedge sys_clk) disable iff (!cfg_rst_n)
    !ce_fall |=> $stable(rs_sel));

  a_r2_no_shift_idle: assert property (@(posedge sys_clk) disable iff (!cfg_rst_n)
    cen_s |=> ($stable(dot_sr) && $stable(ctl_sr)));

  a_r3_dot_hold: assert property (@(posedge sys_clk) disable iff (!cfg_rst_n)
    !fire_dot |=> $stable(dot_q));

  a_r4_single_xfer: assert property (@(posedge sys_clk) disable iff (!cfg_rst_n)
    (fire_dot || fire_ctl) |=> !(fire_dot || fire_ctl));

  a_r4_one_target: assert property (@(posedge sys_clk) disable iff (!cfg_rst_n)
    $onehot0({fire_dot, fire_ctl}));

  a_r5_keep_cw1: assert property (@(posedge sys_clk) disable iff (!cfg_rst_n)
    (fire_ctl && !ctl_sr[CTL_BITS-1]) |=> $stable(cw1));

  a_r5_keep_cw0: assert property (@(posedge sys_clk) disable iff (!cfg_rst_n)
    (fire_ctl && ctl_sr[CTL_BITS-1]) |=> $stable(cw0));

  // R8: control words read zero while the reset is held.
  always @(posedge sys_clk) begin
    if (cfg_rst_n === 1'b0)
      a_r8_words_clear: assert (cw0 == '0 && cw1 == '0);
  end
endmodule

bind ledmx_rx ledmx_rx_chk #(
  .DOT_BITS(DOT_BITS),
  .CTL_BITS(CTL_BITS)
) u_chk (
  .sys_clk  (sys_clk),
  .cfg_rst_n(cfg_rst_n),
  .ce_fall  (ce_fall),
  .cen_s    (cen_s),
  .fire_dot (fire_dot),
  .fire_ctl (fire_ctl),
  .rs_sel   (rs_sel),
  .dot_sr   (dot_sr),
  .ctl_sr   (ctl_sr),
  .dot_q    (dot_q),
  .cw0      (cw0),
  .cw1      (cw1)
);

// File: tb/ledmx_rx_tb.sv
`timescale 1ns/100ps
module ledmx_rx_tb;
  localparam int HOLD = 4;
  localparam logic [159:0] P1 = {5{32'hA5C3_0F1E}};
  localparam logic [159:0] P2 = {5{32'h3C96_E107}};
  localparam logic [159:0] P3 = {10{16'hF00D}};

  logic sys_clk = 1'b0;
  logic rst_n, s_clk, s_ce_n, s_rs, s_din;
  logic ser_dout;
  logic [159:0] dot_q;
  logic [6:0] cw0, cw1;

  always #2.5 sys_clk = ~sys_clk;

  ledmx_rx u_dut (
    .sys_clk  (sys_clk),
    .cfg_rst_n(rst_n),
    .ser_clk  (s_clk),
    .ser_ce_n (s_ce_n),
    .ser_rs   (s_rs),
    .ser_din  (s_din),
    .ser_dout (ser_dout),
    .dot_q    (dot_q),
    .cw0      (cw0),
    .cw1      (cw1)
  );

  int n_chk = 0, n_fail = 0, cycles = 0, dot_updates = 0;
  logic [159:0] last_dot;

  task automatic chk(input bit ok, input string req, input logic [159:0] act, input logic [159:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  logic [3:0] h_clk = 4'h0, h_cen = 4'hF, h_rs = 4'h0, h_din = 4'h0;
  logic [159:0] m_dot_sr = 'x, m_dot_q = 'x;
  logic [7:0]   m_ctl = '0;
  logic [6:0]   m_cw0 = '0, m_cw1 = '0;
  logic         m_sel = 1'b0, m_pend = 1'b0;

  always @(posedge sys_clk) begin
    cycles++;
    if (!rst_n) begin
      h_clk = 4'h0; h_cen = 4'hF; h_rs = 4'h0; h_din = 4'h0;
      m_ctl = '0; m_cw0 = '0; m_cw1 = '0; m_sel = 1'b0; m_pend = 1'b0;
    end else begin
      bit c_clk, p_clk, c_cen, p_cen, rise_ce, fall_ce, fire;
      h_clk = {h_clk[2:0], s_clk};
      h_cen = {h_cen[2:0], s_ce_n};
      h_rs  = {h_rs[2:0], s_rs};
      h_din = {h_din[2:0], s_din};
      c_clk = h_clk[2]; p_clk = h_clk[3];
      c_cen = h_cen[2]; p_cen = h_cen[3];
      rise_ce = c_cen && !p_cen;
      fall_ce = !c_cen && p_cen;
      fire = c_cen && !c_clk && (m_pend || rise_ce);
      if (fire) begin
        if (!m_sel)       m_dot_q = m_dot_sr;
        else if (m_ctl[7]) m_cw1 = m_ctl[6:0];
        else               m_cw0 = m_ctl[6:0];
      end
      m_pend = (m_pend || rise_ce) && c_cen && !fire;
      if (c_clk && !p_clk && !c_cen) begin
        if (!m_sel) m_dot_sr = {m_dot_sr[158:0], h_din[2]};
        else        m_ctl    = {m_ctl[6:0], h_din[2]};
      end
      if (fall_ce) m_sel = h_rs[2];
    end
  end

  // Per-cycle comparison, away from the active edge.
  bit started = 1'b0;
  always @(negedge sys_clk) begin
    if (dot_q !== last_dot) dot_updates++;
    last_dot = dot_q;
    if (started) begin
      logic exp_do;
      if (!$isunknown(m_dot_q))
        chk(dot_q === m_dot_q, "R3 model dot_q", dot_q, m_dot_q);
      chk(cw0 === m_cw0, "R5 model cw0", 160'(cw0), 160'(m_cw0));
      chk(cw1 === m_cw1, "R5 model cw1", 160'(cw1), 160'(m_cw1));
      exp_do = (m_cw1[0] && m_sel) ? s_din : (m_sel ? m_ctl[7] : m_dot_sr[159]);
      if (!$isunknown(exp_do))
        chk(ser_dout === exp_do, "R6/R7 model dout", 160'(ser_dout), 160'(exp_do));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wait_n(input int n);
    repeat (n) @(negedge sys_clk);
    #1;
  endtask

  task automatic pulse(input logic b);
    s_din = b; s_clk = 1'b0; wait_n(HOLD);
    s_clk = 1'b1; wait_n(HOLD);
  endtask

  task automatic begin_wr(input logic rs);
    s_clk = 1'b0; s_rs = rs; wait_n(HOLD);
    s_ce_n = 1'b0; wait_n(HOLD);
  endtask

  task automatic end_wr_low();
    s_clk = 1'b0; wait_n(HOLD);
    s_ce_n = 1'b1; wait_n(HOLD);
  endtask

  task automatic send_dot(input logic [159:0] p);
    for (int i = 159; i >= 0; i--) pulse(p[i]);
  endtask

  task automatic send_ctl(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) pulse(v[i]);
  endtask

  // ---------------- watchdog ----------------
  always @(posedge sys_clk) begin
    if (cycles >= 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  // ---------------- directed sequence ----------------
  initial begin
    int u0;
    rst_n = 1'b0; s_clk = 1'b0; s_ce_n = 1'b1; s_rs = 1'b0; s_din = 1'b0;
    wait_n(6);
    chk(cw0 == 7'h00 && cw1 == 7'h00, "R8 reset clears words", 160'({cw1, cw0}), 160'd0);
    rst_n = 1'b1;
    wait_n(4);
    started = 1'b1;

    // First pixel load; first bit sent lands at bit 159.
    begin_wr(1'b0); send_dot(P1); end_wr_low();
    wait_n(HOLD);
    chk(dot_q === P1, "R2 bit order / R3 load", dot_q, P1);
    chk(ser_dout === P1[159], "R6 dout pixel top bit", 160'(ser_dout), 160'(P1[159]));

    // Clocks with enable high shift nothing.
    for (int k = 0; k < 6; k++) pulse(k[0]);
    s_clk = 1'b0; wait_n(HOLD);
    chk(ser_dout === P1[159], "R2 idle clocks ignored (dout)", 160'(ser_dout), 160'(P1[159]));
    chk(dot_q === P1, "R2 idle clocks ignored (dot_q)", dot_q, P1);

    // Write ends with the serial clock high: no transfer until it falls.
    begin_wr(1'b0); send_dot(P2);
    chk(dot_q === P1, "R3 old pattern during load", dot_q, P1);
    s_ce_n = 1'b1; wait_n(HOLD * 2);
    chk(dot_q === P1, "R3 no latch while clock high", dot_q, P1);
    u0 = dot_updates;
    s_clk = 1'b0; wait_n(2);
    chk(dot_q === P1, "R9 not before third edge", dot_q, P1);
    wait_n(1);
    chk(dot_q === P2, "R9 visible on third edge", dot_q, P2);
    wait_n(HOLD);
    chk(dot_updates - u0 == 1, "R4 one transfer (clock high case)", 160'(dot_updates - u0), 160'd1);

    // Enable rises with clock already low; select moves after capture.
    u0 = dot_updates;
    begin_wr(1'b0); s_rs = 1'b1; send_dot(P3); end_wr_low();
    wait_n(HOLD * 3);
    chk(dot_updates - u0 == 1, "R4 one transfer (clock low case)", 160'(dot_updates - u0), 160'd1);
    chk(dot_q === P3, "R1 late select ignored (pixel target)", dot_q, P3);
    chk(cw0 == 7'h00 && cw1 == 7'h00, "R1 control untouched", 160'({cw1, cw0}), 160'd0);

    // Control word 0, serial output shows control bit 7.
    begin_wr(1'b1); send_ctl(8'h55); end_wr_low(); wait_n(HOLD);
    chk(cw0 == 7'h55, "R5 word 0 loaded", 160'(cw0), 160'h55);
    chk(cw1 == 7'h00, "R5 word 1 kept", 160'(cw1), 160'h00);
    chk(ser_dout === 1'b0, "R6 dout control bit 7 low", 160'(ser_dout), 160'd0);

    begin_wr(1'b1); send_ctl(8'h82); end_wr_low(); wait_n(HOLD);
    chk(cw1 == 7'h02, "R5 word 1 loaded", 160'(cw1), 160'h02);
    chk(cw0 == 7'h55, "R5 word 0 kept", 160'(cw0), 160'h55);
    chk(ser_dout === 1'b1, "R6 dout control bit 7 high", 160'(ser_dout), 160'd1);

    // Pass-through mode.
    begin_wr(1'b1); send_ctl(8'h81); end_wr_low(); wait_n(HOLD);
    chk(cw1 == 7'h01, "R5 pass mode set", 160'(cw1), 160'h01);
    begin_wr(1'b1);
    s_din = 1'b1; wait_n(1);
    chk(ser_dout === 1'b1, "R7 dout follows din high", 160'(ser_dout), 160'd1);
    s_din = 1'b0; wait_n(1);
    chk(ser_dout === 1'b0, "R7 dout follows din low", 160'(ser_dout), 160'd0);
    send_ctl(8'h81); end_wr_low();

    begin_wr(1'b0);
    s_din = ~P3[159]; wait_n(1);
    chk(ser_dout === P3[159], "R7 pixel write stays serial", 160'(ser_dout), 160'(P3[159]));
    send_dot(P1); end_wr_low(); wait_n(HOLD);
    chk(dot_q === P1, "R3 load in pass mode", dot_q, P1);

    // Reset keeps pixel data.
    rst_n = 1'b0; wait_n(3);
    chk(cw0 == 7'h00 && cw1 == 7'h00, "R8 words cleared", 160'({cw1, cw0}), 160'd0);
    chk(dot_q === P1, "R8 dot latch kept", dot_q, P1);
    rst_n = 1'b1; wait_n(4);
    chk(ser_dout === P1[159], "R8 pixel shift kept", 160'(ser_dout), 160'(P1[159]));

    wait_n(4);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule